// File: doc/BRIEF.md
# Serial-Programmed Switch Select Controller

This block is the digital control behind a serially addressed analog multiplexer. A host writes 8-bit control words over a three-wire, write-only link made of an active-low frame strobe, a serial clock and a data line. All three are brought into the system-clock domain, where the serial clock's falling edges are detected and counted. Once a word is complete, it is decoded into one-hot enable vectors that close at most one switch per bank.

The `DUAL_BANK` parameter picks one of two variants. The first is a pair of 16-way banks, A and B, that can be updated independently. The second is a single 32-way bank. Each word carries three things: a turn-off flag, an active-low update mask per bank and a channel address. With these a word can keep, open or reroute each bank. When a bank moves from one closed switch to another, its enables pass through an all-zero gap first, so no two channels are ever joined. An active-low asynchronous clear empties the receiver and opens every switch, and this is also the power-on state.

Top module: `ssw_select_ctrl`

## Requirements
- R1: While `clr_n` is low, both enable outputs are zero, the shift register is emptied, and any partly received word is lost.
- R2: `sdi` is sampled only on falling edges of `sclk` that occur while `frm_n` is low, and the first bit sampled becomes word bit 7 (the first bit is the MSB).
- R3: The eighth falling edge of a frame commits the word. Any further edges in the same frame are ignored.
- R4: While `frm_n` is high, activity on `sclk` and `sdi` leaves the outputs unchanged.
- R5: If `frm_n` rises after fewer than eight falling edges, the partial word is discarded and the next frame starts counting from zero.
- R6: In dual-bank mode, word bit 7 is the turn-off flag, bit 6 is the active-low update mask for bank A, bit 5 is the mask for bank B, and bits 3..0 are the address. Bit 4 is ignored.
- R7: In single-bank mode, bit 7 is the turn-off flag, bit 6 is the active-low update mask, and bits 4..0 are the address. Bit 5 is ignored, and `sw_en_b` stays zero.
- R8: A bank whose mask bit is 1 keeps its previous enables.
- R9: A committed word with bit 7 set clears the enables of every unmasked bank.
- R10: A committed word with bit 7 clear sets only enable bit n of each unmasked bank, where n is the address. An enable vector never has more than one bit set.
- R11: When a bank changes from one closed switch to a different one, its enables are all zero for at least `GAP_CYCLES` system-clock cycles between the two values.
- R12: A falling edge that is synchronized in the same system-clock cycle as the rising edge of `frm_n` still counts toward the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run at least four times the `sclk` rate |
| clr_n | input | 1 | Asynchronous active-low clear and power-on reset |
| frm_n | input | 1 | Active-low frame strobe of the serial link |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, MSB first |
| sw_en_a | output | BANK_CH | One-hot enables of bank A (the only bank in single-bank mode) |
| sw_en_b | output | BANK_CH | One-hot enables of bank B; zero in single-bank mode |

## Verification
Two events can land in the same system-clock cycle: the eighth serial-clock fall and the end of the frame. The bench provokes this by raising `frm_n` on the same system-clock edge where it lowers `sclk` for the last bit, so both pass through synchronizers of equal depth and arrive together. The run passes only if that word is committed just like a normally framed word. A reference model in the bench follows the expected bank states, and every clock is also screened for a second set enable bit and for a direct jump between two different closed switches.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
   localparam int WORD_W = 8;

   typedef struct packed {
      logic       off;
      logic       keep_a;
      logic       keep_b;
      logic [4:0] addr;
   } ssw_ctl_t;

   // Split a received word into its control fields for the chosen variant.
   function automatic ssw_ctl_t ssw_decode(input logic [WORD_W-1:0] w, input bit dual);
      ssw_ctl_t c;
      c.off    = w[7];
      c.keep_a = w[6];
      c.keep_b = dual ? w[5] : 1'b1;
      c.addr   = dual ? {1'b0, w[3:0]} : w[4:0];
      return c;
   endfunction
endpackage

// File: rtl/ssw_sync_edge.sv
module ssw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   input  logic frm_n,
   input  logic sclk,
   input  logic sdi,
   output logic frm_act,
   output logic sclk_fall,
   output logic sdi_s
);
   localparam int         NSIG = 3;
   localparam logic [2:0] RST_VAL = 3'b100;   // frame idle high, clock and data low

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ssw_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [NSIG-1:0]   raw;
   logic [STAGES-1:0] chain [NSIG];
   logic              sclk_prev;

   assign raw = {frm_n, sclk, sdi};

   for (genvar g = 0; g < NSIG; g++) begin : g_sync
      always_ff @(posedge clk or negedge clr_n) begin
         if (!clr_n) chain[g] <= {STAGES{RST_VAL[g]}};
         else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
      end
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) sclk_prev <= 1'b0;
      else        sclk_prev <= chain[1][STAGES-1];
   end

   assign frm_act   = ~chain[2][STAGES-1];
   assign sclk_fall = sclk_prev & ~chain[1][STAGES-1];
   assign sdi_s     = chain[0][STAGES-1];
endmodule

// File: rtl/ssw_shift_rx.sv
module ssw_shift_rx #(
   parameter int WORD_W = 8,
   localparam int CW    = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              frm_act,
   input  logic              sclk_fall,
   input  logic              sdi_s,
   output logic              word_vld,
   output logic [WORD_W-1:0] word,
   output logic [CW-1:0]     bit_cnt
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("ssw_shift_rx: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] shreg;
   logic              frm_was;
   logic              take;

   // An edge seen in the cycle the frame closes still belongs to it.
   assign take = sclk_fall && (frm_act || frm_was) && (bit_cnt < CW'(WORD_W));

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         shreg    <= '0;
         bit_cnt  <= '0;
         word_vld <= 1'b0;
         word     <= '0;
         frm_was  <= 1'b0;
      end else begin
         frm_was  <= frm_act;
         word_vld <= 1'b0;
         if (take) begin
            shreg   <= {shreg[WORD_W-2:0], sdi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CW'(WORD_W - 1)) begin
               word_vld <= 1'b1;
               word     <= {shreg[WORD_W-2:0], sdi_s};
            end
         end else if (!frm_act) begin
            bit_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/ssw_bank_drv.sv
module ssw_bank_drv #(
   parameter int CH  = 16,
   parameter int GAP = 1,
   localparam int AW = $clog2(CH),
   localparam int GW = $clog2(GAP + 1)
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          upd,
   input  logic          off,
   input  logic [AW-1:0] addr,
   output logic [CH-1:0] en
);
   generate
      if (GAP < 1) begin : g_bad_gap
         $error("ssw_bank_drv: GAP must be at least 1");
      end
      if (CH < 2) begin : g_bad_ch
         $error("ssw_bank_drv: CH must be at least 2");
      end
   endgenerate

   logic [CH-1:0] en_q;
   logic [CH-1:0] want_vec;
   logic [CH-1:0] tgt_vec;
   logic [AW-1:0] tgt;
   logic [GW-1:0] gcnt;
   logic          pend;

   always_comb begin
      want_vec       = '0;
      want_vec[addr] = 1'b1;
      tgt_vec        = '0;
      tgt_vec[tgt]   = 1'b1;
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         en_q <= '0;
         pend <= 1'b0;
         tgt  <= '0;
         gcnt <= '0;
      end else if (upd) begin
         if (off) begin
            en_q <= '0;
            pend <= 1'b0;
         end else if (en_q == want_vec) begin
            pend <= 1'b0;
         end else if (en_q == '0) begin
            en_q <= want_vec;
            pend <= 1'b0;
         end else begin
            en_q <= '0;              // open first, close later
            pend <= 1'b1;
            tgt  <= addr;
            gcnt <= GW'(GAP - 1);
         end
      end else if (pend) begin
         if (gcnt == '0) begin
            en_q <= tgt_vec;
            pend <= 1'b0;
         end else begin
            gcnt <= gcnt - 1'b1;
         end
      end
   end

   assign en = en_q;
endmodule

// File: rtl/ssw_select_ctrl.sv
module ssw_select_ctrl #(
   parameter bit  DUAL_BANK   = 1'b1,
   parameter int  SYNC_STAGES = 2,
   parameter int  GAP_CYCLES  = 1,
   localparam int BANK_CH     = DUAL_BANK ? 16 : 32,
   localparam int AW          = $clog2(BANK_CH),
   localparam int CW          = $clog2(ssw_pkg::WORD_W + 1)
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               frm_n,
   input  logic               sclk,
   input  logic               sdi,
   output logic [BANK_CH-1:0] sw_en_a,
   output logic [BANK_CH-1:0] sw_en_b
);
   import ssw_pkg::*;

   logic              frm_act;
   logic              sclk_fall;
   logic              sdi_s;
   logic              word_vld;
   logic [WORD_W-1:0] word;
   logic [CW-1:0]     bit_cnt;
   ssw_ctl_t          ctl;

   ssw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .clr_n(clr_n), .frm_n(frm_n), .sclk(sclk), .sdi(sdi),
      .frm_act(frm_act), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
   );

   ssw_shift_rx #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .clr_n(clr_n), .frm_act(frm_act), .sclk_fall(sclk_fall),
      .sdi_s(sdi_s), .word_vld(word_vld), .word(word), .bit_cnt(bit_cnt)
   );

   assign ctl = ssw_decode(word, DUAL_BANK);

   ssw_bank_drv #(.CH(BANK_CH), .GAP(GAP_CYCLES)) u_bank_a (
      .clk(clk), .clr_n(clr_n), .upd(word_vld && !ctl.keep_a),
      .off(ctl.off), .addr(ctl.addr[AW-1:0]), .en(sw_en_a)
   );

   generate
      if (DUAL_BANK) begin : g_dual
         ssw_bank_drv #(.CH(BANK_CH), .GAP(GAP_CYCLES)) u_bank_b (
            .clk(clk), .clr_n(clr_n), .upd(word_vld && !ctl.keep_b),
            .off(ctl.off), .addr(ctl.addr[AW-1:0]), .en(sw_en_b)
         );
      end else begin : g_single
         assign sw_en_b = '0;
      end
   endgenerate
endmodule

// File: rtl/ssw_select_chk.sv
module ssw_select_chk #(
   parameter bit  DUAL_BANK = 1'b1,
   parameter int  BANK_CH   = 16,
   parameter int  WORD_W    = 8,
   localparam int CW        = $clog2(WORD_W + 1)
) (
   input logic               clk,
   input logic               clr_n,
   input logic [BANK_CH-1:0] en_a,
   input logic [BANK_CH-1:0] en_b,
   input logic               cmt,
   input logic [WORD_W-1:0]  word,
   input logic               frm_act,
   input logic [CW-1:0]      bit_cnt
);
   // R1: clear forces every switch open
   a_r1_clear_opens: assert property (@(posedge clk)
      !clr_n |-> (en_a == '0 && en_b == '0));

   // R10: at most one switch per bank
   a_r10_onehot_a: assert property (@(posedge clk) disable iff (!clr_n) $onehot0(en_a));
   a_r10_onehot_b: assert property (@(posedge clk) disable iff (!clr_n) $onehot0(en_b));

   // R11: no direct hop between two closed switches
   a_r11_gap_a: assert property (@(posedge clk) disable iff (!clr_n)
      (en_a != '0 && $past(en_a) != '0) |-> en_a == $past(en_a));
   a_r11_gap_b: assert property (@(posedge clk) disable iff (!clr_n)
      (en_b != '0 && $past(en_b) != '0) |-> en_b == $past(en_b));

   // R3: the bit counter never runs past one word
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!clr_n)
      bit_cnt <= CW'(WORD_W));

   // R4: a commit only follows a cycle in which the frame was open
   a_r4_commit_in_frame: assert property (@(posedge clk) disable iff (!clr_n)
      cmt |-> ($past(frm_act) || $past(frm_act, 2)));

   // R9: turn-off word clears an unmasked bank A
   a_r9_off_a: assert property (@(posedge clk) disable iff (!clr_n)
      (cmt && word[7] && !word[6]) |=> en_a == '0);

   // R7: single-bank variant leaves bank B idle
   a_r7_b_idle: assert property (@(posedge clk) disable iff (!clr_n)
      !DUAL_BANK |-> en_b == '0);
endmodule

bind ssw_select_ctrl ssw_select_chk #(
   .DUAL_BANK(DUAL_BANK), .BANK_CH(BANK_CH), .WORD_W(ssw_pkg::WORD_W)
) u_chk (
   .clk(clk), .clr_n(clr_n), .en_a(sw_en_a), .en_b(sw_en_b),
   .cmt(word_vld), .word(word), .frm_act(frm_act), .bit_cnt(bit_cnt)
);

// File: tb/test_ssw_select_ctrl.sv
module test_ssw_select_ctrl;
   logic        clk = 1'b0;
   logic        clr_n = 1'b0;
   logic        frm_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic [15:0] en_a, en_b;
   logic [31:0] en_s, en_s_b;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   // reference state: closed channel index, -1 means all open
   int ea = -1, eb = -1, es = -1;

   always #4 clk = ~clk;   // 125 MHz

   ssw_select_ctrl #(.DUAL_BANK(1'b1)) i_ssw_select_ctrl (
      .clk(clk), .clr_n(clr_n), .frm_n(frm_n), .sclk(sclk), .sdi(sdi),
      .sw_en_a(en_a), .sw_en_b(en_b)
   );

   ssw_select_ctrl #(.DUAL_BANK(1'b0)) i_ssw_select_ctrl_w (
      .clk(clk), .clr_n(clr_n), .frm_n(frm_n), .sclk(sclk), .sdi(sdi),
      .sw_en_a(en_s), .sw_en_b(en_s_b)
   );

   function automatic logic [31:0] vec(input int idx);
      return (idx < 0) ? 32'h0 : (32'h1 << idx);
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic chk_all(input string rq);
      chk({rq, " bank A"}, {16'h0, en_a}, vec(ea));
      chk({rq, " bank B"}, {16'h0, en_b}, vec(eb));
      chk({rq, " single"}, en_s, vec(es));
      chk({rq, " single B idle (R7)"}, en_s_b, 32'h0);
   endtask

   function automatic void model_apply(input logic [7:0] w);
      if (!w[6]) ea = w[7] ? -1 : int'(w[3:0]);
      if (!w[5]) eb = w[7] ? -1 : int'(w[3:0]);
      if (!w[6]) es = w[7] ? -1 : int'(w[4:0]);
   endfunction

   // per-clock screen: one-hot and break-before-make (R10, R11)
   logic [15:0] pa = '0, pb = '0;
   logic [31:0] ps = '0;
   always @(negedge clk) begin
      if (mon_on && clr_n) begin
         compared++;
         if (!$onehot0(en_a) || !$onehot0(en_b) || !$onehot0(en_s)) begin
            mismatched++;
            $display("FAIL R10 actual=%h/%h/%h expected=at most one bit each", en_a, en_b, en_s);
         end
         if ((pa != 0 && en_a != 0 && pa != en_a) || (pb != 0 && en_b != 0 && pb != en_b)
             || (ps != 0 && en_s != 0 && ps != en_s)) begin
            mismatched++;
            $display("FAIL R11 actual=%h/%h/%h expected=zero gap after %h/%h/%h",
                     en_a, en_b, en_s, pa, pb, ps);
         end
      end
      pa = en_a; pb = en_b; ps = en_s;
   end

   task automatic bit_out(input logic b, input bit rel_on_fall);
      sdi  = b;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (rel_on_fall) frm_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] w, input int n, input bit edge_rel);
      frm_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         logic b;
         b = (i < 8) ? w[7-i] : logic'(i % 2);
         bit_out(b, edge_rel && (i == n - 1));
      end
      frm_n = 1'b1;
      repeat (12) @(negedge clk);
      if (n >= 8) model_apply(w);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk_all("R1 reset");
      clr_n = 1'b1;
      mon_on = 1'b1;
      repeat (5) @(negedge clk);
      chk_all("R1 after release");

      send(8'b0000_0101, 8, 1'b0);
      chk_all("R2 R6 R7 R10 route both to 5");

      send(8'b0011_1010, 8, 1'b0);          // bank B masked; bit4 ignored in dual, bit5 ignored in single
      chk_all("R6 R7 R8 reroute A only");

      send(8'b0110_0011, 8, 1'b0);          // both masks high
      chk_all("R8 keep all");

      send(8'b1100_0000, 8, 1'b0);          // off flag, only bank B unmasked
      chk_all("R9 B off");

      send(8'b0000_0001, 5, 1'b0);          // short frame
      chk_all("R5 partial dropped");

      // activity while the frame is idle (R4)
      for (int i = 0; i < 6; i++) bit_out(logic'(i % 2 == 0), 1'b0);
      repeat (8) @(negedge clk);
      chk_all("R4 idle noise");

      send(8'b0000_1111, 12, 1'b0);         // four surplus edges
      chk_all("R3 extra edges ignored");

      send(8'b0000_0000, 8, 1'b0);          // 15 -> 0 crosses the gap
      chk_all("R11 R10 reroute to 0");

      send(8'b0000_0110, 8, 1'b1);          // frame closes with the last edge
      chk_all("R12 edge with release");

      // clear mid-frame (R1)
      frm_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
      clr_n = 1'b0;
      ea = -1; eb = -1; es = -1;
      repeat (2) @(negedge clk);
      chk_all("R1 clear mid-frame");
      clr_n = 1'b1;
      for (int i = 0; i < 4; i++) bit_out(1'b1, 1'b0);
      frm_n = 1'b1;
      repeat (12) @(negedge clk);
      chk_all("R1 R5 remainder dropped");

      send(8'b0001_0011, 8, 1'b0);
      chk_all("R2 R7 after clear");

      send(8'b1000_0000, 8, 1'b0);          // off flag, all unmasked
      chk_all("R9 all off");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule